// File: doc/BRIEF.md
# Byte-Buffered Serial Master with Gap Control

This block is a serial-peripheral master for clock mode 0. It sends bytes MSB first on a data-out line and reads a data-in line at the same time. It has a one-entry holding register, so the host can queue the next byte while the current byte is still on the wire. If the queued byte is already waiting when the eighth bit ends, the serial clock keeps running at an even rate. If nothing is queued, the block stops the clock after the byte, holds it low for one half period, and then releases the select line.

The high and low phases of the serial clock are each set in system-clock cycles. Timing is fixed by cycle counts, so a slow slave gets a guaranteed minimum pulse width. An optional gap count holds the clock low after every byte, which gives a slave that services each byte in firmware time to do so. Each received byte appears on a parallel output together with a one-cycle strobe.

Top module: `spi_byte_master`

## Requirements
- R1: While reset is high and on the first cycle after it, cs_n is 1, sclk is 0, tx_ready is 1 and byte_ready is 0.
- R2: tx_ready is 1 exactly when the holding register is empty. An accepted write (tx_write with tx_ready at 1) makes tx_ready 0 on the next cycle. tx_ready returns to 1 once the byte moves into the shifter.
- R3: Bytes leave on mosi MSB first. mosi changes only while sclk is low and stays stable for the whole of each high phase.
- R4: miso is sampled at each rising sclk edge, MSB first. After the eighth falling edge of a byte, rx_data holds the eight sampled bits and byte_ready is 1 for exactly one cycle.
- R5: Each sclk high phase and each low phase lasts at least max(cfg_half,1) system clocks. A cfg_half of 0 acts as 1.
- R6: cs_n goes low exactly max(cfg_half,1) cycles before the first rising sclk edge of a transfer.
- R7: If cfg_gap is 0 and the next byte is queued before the eighth falling edge, the next rising edge comes one half period later. The pulse train stays uniform across the byte boundary and cs_n stays low.
- R8: With nothing queued, sclk stops low after a multiple of eight pulses. cs_n rises max(cfg_half,1) cycles after the last falling edge when cfg_gap is 0.
- R9: With cfg_gap nonzero, sclk is held low for cfg_gap plus max(cfg_half,1) cycles after each byte's eighth falling edge before the next rising edge.
- R10: A write while the holding register is full is ignored. The byte it carried is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | CNT_W | Length of the sclk high and low phases in cycles (0 acts as 1) |
| cfg_gap | input | CNT_W | Extra low cycles after each byte (0 disables) |
| tx_data | input | 8 | Byte to queue |
| tx_write | input | 1 | Write strobe for tx_data |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | 8 | Last received byte |
| byte_ready | output | 1 | One-cycle strobe: rx_data valid |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low slave select |

## Verification
Embedded properties check these behaviours on every cycle:
- mosi stays stable through every high phase.
- byte_ready never lasts two cycles.
- An accepted write always fills the holding register.
- A write while full leaves the held byte alone.
- Neither sclk phase is ever shorter than the configured half period.

Other behaviours need directed scenarios with a slave model:
- byte ordering on both data lines;
- the exact setup and release distances of cs_n;
- the even pulse train across byte boundaries;
- the stretched low time when a gap is set;
- the loss of a byte written while full.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_LOW,
        PH_GAP
    } phase_e;

    typedef struct packed {
        byte_t             tx;
        byte_t             rx;
        logic [IDX_W-1:0]  idx;
        logic              tail;
    } shift_t;

    function automatic logic last_bit(input logic [IDX_W-1:0] idx);
        return idx == IDX_W'(BYTE_W - 1);
    endfunction

endpackage

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_eff;

    assign lim_eff = (limit == '0) ? CNT_W'(1) : limit;
    assign expired = (cnt >= lim_eff - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/spi_hold_reg.sv
module spi_hold_reg
    import spi_gap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  byte_t wr_data,
    input  logic  take,
    output logic  full,
    output byte_t data
);
    logic accept;
    assign accept = wr_en && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else begin
            if (take)
                full <= 1'b0;
            else if (accept)
                full <= 1'b1;
            if (accept)
                data <= wr_data;
        end
    end

    // R10: a write while full leaves the held byte untouched
    a_r10_full_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> $stable(data));

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_gap_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_half,
    input  logic [CNT_W-1:0] cfg_gap,
    input  logic [7:0]       tx_data,
    input  logic             tx_write,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             byte_ready,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    phase_e           phase, phase_nx;
    shift_t           sh;
    logic             step, take, expired;
    logic             hold_full;
    byte_t            hold_data;
    byte_t            rx_q;
    logic             br_q;
    logic [CNT_W-1:0] tim_lim;

    spi_hold_reg u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tx_write),
        .wr_data (tx_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    assign tim_lim = (phase == PH_GAP) ? cfg_gap : cfg_half;

    spi_phase_timer #(.CNT_W(CNT_W)) u_tim (
        .clk     (clk),
        .rst     (rst),
        .restart (step),
        .limit   (tim_lim),
        .expired (expired)
    );

    always_comb begin
        phase_nx = phase;
        step     = 1'b0;
        take     = 1'b0;
        unique case (phase)
            PH_IDLE: if (hold_full) begin
                take = 1'b1; step = 1'b1; phase_nx = PH_SETUP;
            end
            PH_SETUP: if (expired) begin
                step = 1'b1; phase_nx = PH_HIGH;
            end
            PH_HIGH: if (expired) begin
                step = 1'b1;
                if (last_bit(sh.idx) && cfg_gap != '0)
                    phase_nx = PH_GAP;
                else begin
                    phase_nx = PH_LOW;
                    take     = last_bit(sh.idx) && hold_full;
                end
            end
            PH_LOW: if (expired) begin
                step = 1'b1;
                if (!sh.tail)
                    phase_nx = PH_HIGH;
                else if (hold_full)
                    take = 1'b1;
                else
                    phase_nx = PH_IDLE;
            end
            PH_GAP: if (expired) begin
                step = 1'b1; take = hold_full; phase_nx = PH_LOW;
            end
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            sh    <= '0;
            rx_q  <= '0;
            br_q  <= 1'b0;
        end else begin
            phase <= phase_nx;
            br_q  <= (phase == PH_HIGH) && expired && last_bit(sh.idx);
            if (step && phase_nx == PH_HIGH)
                sh.rx <= {sh.rx[BYTE_W-2:0], miso};
            if ((phase == PH_HIGH) && expired && last_bit(sh.idx))
                rx_q <= sh.rx;
            if (take) begin
                sh.tx   <= hold_data;
                sh.idx  <= '0;
                sh.tail <= 1'b0;
            end else if ((phase == PH_HIGH) && expired) begin
                if (!last_bit(sh.idx)) begin
                    sh.tx  <= {sh.tx[BYTE_W-2:0], 1'b0};
                    sh.idx <= sh.idx + IDX_W'(1);
                end else if (cfg_gap == '0)
                    sh.tail <= 1'b1;
            end else if ((phase == PH_GAP) && expired)
                sh.tail <= 1'b1;
        end
    end

    assign sclk       = (phase == PH_HIGH);
    assign cs_n       = (phase == PH_IDLE);
    assign mosi       = sh.tx[BYTE_W-1];
    assign tx_ready   = !hold_full;
    assign rx_data    = rx_q;
    assign byte_ready = br_q;

    // ---- assertion support: phase run lengths ----
    logic [CNT_W:0]   hi_run, lo_run;
    logic [CNT_W-1:0] half_eff;
    assign half_eff = (cfg_half == '0) ? CNT_W'(1) : cfg_half;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= !sclk ? '0 : (hi_run == '1 ? hi_run : hi_run + 1'b1);
            lo_run <=  sclk ? '0 : (lo_run == '1 ? lo_run : lo_run + 1'b1);
        end
    end

    a_r3_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        byte_ready |=> !byte_ready);

    a_r5_high_width: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (hi_run >= {1'b0, half_eff}));

    a_r5_low_width: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> (lo_run >= {1'b0, half_eff}));

    a_r2_write_fills: assert property (@(posedge clk) disable iff (rst)
        (tx_write && tx_ready) |=> !tx_ready);

endmodule

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] cfg_half = 8'd3;
    logic [CNT_W-1:0] cfg_gap  = 8'd0;
    logic [7:0]       tx_data  = 8'h00;
    logic             tx_write = 1'b0;
    logic             tx_ready, byte_ready, sclk, mosi, miso, cs_n;
    logic [7:0]       rx_data;

    always #10 clk = ~clk;

    spi_byte_master #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .cfg_half(cfg_half), .cfg_gap(cfg_gap),
        .tx_data(tx_data), .tx_write(tx_write), .tx_ready(tx_ready),
        .rx_data(rx_data), .byte_ready(byte_ready), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int n_chk = 0;
    int n_bad = 0;

    // ---- monitor and slave model ----
    logic       mon_clr = 1'b0;
    logic [7:0] slv_pat = 8'h00;
    logic [2:0] slv_idx = 3'd0;
    logic [7:0] mosi_acc = 8'h00;
    logic [7:0] got [0:7];
    logic [7:0] rxg [0:7];
    logic       p_sclk = 1'b0, p_cs = 1'b1, p_br = 1'b0, first_rise = 1'b0;
    int cyc = 0, rise_n = 0, got_n = 0, rx_n = 0, br_dbl = 0, cs_rise_n = 0;
    int last_rise = 0, last_fall = 0, cs_fall = 0, setup_len = 0, tail_len = 0;
    int min_hi = 1000, max_hi = 0, min_lo = 1000, max_lo = 0;

    assign miso = slv_pat[3'd7 - slv_idx];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_clr) begin
            rise_n = 0; got_n = 0; rx_n = 0; br_dbl = 0; cs_rise_n = 0;
            min_hi = 1000; max_hi = 0; min_lo = 1000; max_lo = 0;
            slv_idx = 3'd0; setup_len = 0; tail_len = 0; first_rise = 1'b0;
        end else begin
            if (!cs_n && p_cs) begin
                cs_fall = cyc; first_rise = 1'b1;
            end
            if (sclk && !p_sclk) begin
                rise_n = rise_n + 1;
                mosi_acc = {mosi_acc[6:0], mosi};
                if (rise_n % 8 == 0 && got_n < 8) begin
                    got[got_n] = mosi_acc; got_n = got_n + 1;
                end
                if (first_rise) setup_len = cyc - cs_fall;
                else begin
                    if (cyc - last_fall < min_lo) min_lo = cyc - last_fall;
                    if (cyc - last_fall > max_lo) max_lo = cyc - last_fall;
                end
                first_rise = 1'b0;
                last_rise = cyc;
            end
            if (!sclk && p_sclk) begin
                if (cyc - last_rise < min_hi) min_hi = cyc - last_rise;
                if (cyc - last_rise > max_hi) max_hi = cyc - last_rise;
                last_fall = cyc;
                slv_idx = slv_idx + 3'd1;
            end
            if (cs_n && !p_cs) begin
                tail_len = cyc - last_fall; cs_rise_n = cs_rise_n + 1;
            end
            if (byte_ready) begin
                if (rx_n < 8) rxg[rx_n] = rx_data;
                rx_n = rx_n + 1;
                if (p_br) br_dbl = br_dbl + 1;
            end
        end
        p_sclk = sclk; p_cs = cs_n; p_br = byte_ready;
    end

    // ---- helpers ----
    task automatic chk(input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk) mon_clr = 1'b1;
        @(negedge clk) mon_clr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk) begin tx_data = b; tx_write = 1'b1; end
        @(negedge clk) tx_write = 1'b0;
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!tx_ready);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (cs_n);
        do @(negedge clk); while (!(cs_n && tx_ready));
        repeat (3) @(negedge clk);
    endtask

    // ---- scenarios ----
    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk("R1 cs_n in reset", int'(cs_n), 1);
        chk("R1 sclk in reset", int'(sclk), 0);
        chk("R1 tx_ready in reset", int'(tx_ready), 1);
        chk("R1 byte_ready in reset", int'(byte_ready), 0);
        @(negedge clk) rst = 1'b0;
        chk("R1 cs_n after reset", int'(cs_n), 1);
        chk("R1 sclk after reset", int'(sclk), 0);
    endtask

    task automatic t_single();
        cfg_half = 8'd3; cfg_gap = 8'd0; slv_pat = 8'h3C;
        clear_mon();
        wr(8'hA5);
        wait_done();
        chk("R3 mosi byte", int'(got[0]), 8'hA5);
        chk("R4 rx byte", int'(rxg[0]), 8'h3C);
        chk("R4 strobe count", rx_n, 1);
        chk("R4 strobe width", br_dbl, 0);
        chk("R5 min high", min_hi, 3);
        chk("R5 min low", min_lo, 3);
        chk("R6 cs setup", setup_len, 3);
        chk("R8 pulse count", rise_n, 8);
        chk("R8 cs release", tail_len, 3);
        repeat (20) @(negedge clk);
        chk("R8 clock stays stopped", rise_n, 8);
    endtask

    task automatic t_back_to_back();
        cfg_half = 8'd2; cfg_gap = 8'd0; slv_pat = 8'hC3;
        clear_mon();
        wr(8'h81);
        wait_ready(); wr(8'h7E);
        wait_ready(); wr(8'h55);
        wait_done();
        chk("R7 pulses", rise_n, 24);
        chk("R7 byte0", int'(got[0]), 8'h81);
        chk("R7 byte1", int'(got[1]), 8'h7E);
        chk("R7 byte2", int'(got[2]), 8'h55);
        chk("R7 max low", max_lo, 2);
        chk("R7 max high", max_hi, 2);
        chk("R7 cs stays low", cs_rise_n, 1);
        chk("R4 rx strobes", rx_n, 3);
        chk("R4 rx last", int'(rxg[2]), 8'hC3);
    endtask

    task automatic t_gap();
        cfg_half = 8'd2; cfg_gap = 8'd10; slv_pat = 8'h96;
        clear_mon();
        wr(8'hF0);
        wait_ready(); wr(8'h0F);
        wait_done();
        chk("R9 byte0", int'(got[0]), 8'hF0);
        chk("R9 byte1", int'(got[1]), 8'h0F);
        chk("R9 gap low", max_lo, 12);
        chk("R9 in-byte low", min_lo, 2);
        chk("R9 rx", int'(rxg[1]), 8'h96);
    endtask

    task automatic t_full();
        cfg_half = 8'd4; cfg_gap = 8'd0; slv_pat = 8'h00;
        clear_mon();
        wr(8'h11);
        wait_ready(); wr(8'h22);
        chk("R2 ready low when held", int'(tx_ready), 0);
        wr(8'h33);
        wait_done();
        chk("R10 pulses", rise_n, 16);
        chk("R10 byte0", int'(got[0]), 8'h11);
        chk("R10 byte1 not overwritten", int'(got[1]), 8'h22);
        chk("R2 ready after drain", int'(tx_ready), 1);
    endtask

    task automatic t_min_half();
        cfg_half = 8'd0; cfg_gap = 8'd0; slv_pat = 8'h5A;
        clear_mon();
        wr(8'hE7);
        wait_done();
        chk("R5 zero half high", min_hi, 1);
        chk("R5 zero half low", min_lo, 1);
        chk("R3 fast byte", int'(got[0]), 8'hE7);
        chk("R4 fast rx", int'(rxg[0]), 8'h5A);
    endtask

    initial begin
        t_reset();
        t_single();
        t_back_to_back();
        t_gap();
        t_full();
        t_min_half();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog act=timeout exp=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule